// File: doc/BRIEF.md
# Bi-Mode Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken, and learns from the outcome once the branch has resolved. Two tables of saturating counters hold the direction guesses. The taken-leaning table is meant to collect entries that mostly go taken. The not-taken-leaning table is meant to collect entries that mostly fall through. A third table, the choice table, is indexed by the branch address alone. For each address it decides which of the two direction tables gives the answer. The direction tables are indexed by the branch address mixed with a global history of recent outcomes. Splitting the counters this way keeps branches with opposite habits from overwriting each other's state.

A fetch unit presents the branch address index on the lookup port. In the same cycle it receives the predicted direction and the history value that was used. When the branch resolves, the pipeline presents the same address index, the true outcome and the history captured at lookup time on the update port. The tables are trained on the next clock edge. The global history register shifts in each resolved outcome.

Top module: `bimode_predictor`

## Requirements
- R1: After reset, every lookup predicts not-taken (lk_taken = 0).
- R2: Each counter is CTR_W bits wide (2 by default). It steps up by one on a taken outcome and down by one on a not-taken outcome. The direction it gives is its most significant bit (1 = taken).
- R3: The choice table is indexed by the address index only. The direction tables are indexed by the address index XOR the history, where history bit j is folded onto index bit j mod IDX_W.
- R4: When the most significant bit of the choice counter is 1, the prediction comes from the taken-leaning table. When it is 0, the prediction comes from the not-taken-leaning table.
- R5: An update trains only the direction table that its choice counter selected. The entry in the other table is left unchanged.
- R6: The choice counter steps toward the outcome, except when the choice direction disagreed with the outcome while the selected direction counter agreed with it. In that case the choice counter holds.
- R7: The history register resets to 0. On each valid update it becomes {old[HIST_W-2:0], outcome}, and without an update it holds. lk_hist always shows it.
- R8: At reset the taken-leaning entries start at weakly taken (binary 10). The not-taken-leaning entries start at weakly not-taken (01). The choice entries start at weakly not-taken (01).
- R9: Counters saturate: a taken outcome at the maximum value and a not-taken outcome at zero leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc_idx | input | IDX_W | Lookup branch address index (address bits above instruction alignment) |
| lk_taken | output | 1 | Predicted direction, 1 = taken, combinational from lookup index |
| lk_hist | output | HIST_W | Global history used for the current lookup |
| upd_valid | input | 1 | Resolved branch present on the update port |
| upd_pc_idx | input | IDX_W | Address index of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | HIST_W | History value captured when this branch was predicted |

## Verification
A counter that is wrong inside any table stays hidden until a lookup lands on that entry while the choice entry points at that table. After that it shows as a flipped lk_taken in the same cycle. A choice entry trained or held wrongly moves a whole address to the other table, so it shows at once on any history value whose two direction entries still disagree. The bench therefore arranges histories that reach untouched entries, and it compares every lookup against a model built from the requirements across long mixed update streams. A wrong history register shows on lk_hist in the cycle after the update.

// File: rtl/bimode_pkg.sv
package bimode_pkg;

  // One saturating step of a counter that is `width` bits wide (width <= 8).
  function automatic logic [7:0] sat_step(input logic [7:0] cur,
                                          input logic up,
                                          input int unsigned width);
    logic [7:0] top_v;
    top_v = 8'((16'd1 << width) - 16'd1);
    if (up) return (cur >= top_v) ? top_v : cur + 8'd1;
    else    return (cur == 8'd0) ? 8'd0 : cur - 8'd1;
  endfunction

  // Reset value for a counter leaning one way but only weakly.
  function automatic logic [7:0] weak_value(input logic lean_taken,
                                            input int unsigned width);
    logic [7:0] mid;
    mid = 8'(16'd1 << (width - 1));
    return lean_taken ? mid : mid - 8'd1;
  endfunction

endpackage

// File: rtl/bimode_index_hash.sv
module bimode_index_hash #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic [IDX_W-1:0]  pc_idx,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  dir_idx
);

  logic [IDX_W-1:0] folded;

  // History wider than the index is folded back over it by XOR.
  always_comb begin
    folded = '0;
    for (int j = 0; j < HIST_W; j++) begin
      folded[j % IDX_W] = folded[j % IDX_W] ^ hist[j];
    end
  end

  assign dir_idx = pc_idx ^ folded;

endmodule

// File: rtl/bimode_ctr_table.sv
module bimode_ctr_table #(
  parameter int         IDX_W = 10,
  parameter int         CTR_W = 2,
  parameter logic [7:0] INIT  = 8'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  output logic             lk_pred,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_pred,
  input  logic             up_we,
  input  logic             up_dir
);

  localparam int               DEPTH   = 1 << IDX_W;
  localparam logic [CTR_W-1:0] RST_VAL = INIT[CTR_W-1:0];
  localparam logic [CTR_W-1:0] MAX_VAL = '1;

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] up_cur;
  logic [CTR_W-1:0] up_nxt;

  assign up_cur  = mem[up_idx];
  assign up_pred = up_cur[CTR_W-1];
  assign lk_pred = mem[lk_idx][CTR_W-1];
  assign up_nxt  = CTR_W'(bimode_pkg::sat_step(8'(up_cur), up_dir, CTR_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (up_we) begin
      mem[up_idx] <= up_nxt;
    end
  end

  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_we && up_dir && up_cur == MAX_VAL) |=> (mem[$past(up_idx)] == MAX_VAL)); // R9

  AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (up_we && !up_dir && up_cur == '0) |=> (mem[$past(up_idx)] == '0)); // R9

  AST_UNWRITTEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_we) |=> (mem[$past(up_idx)] == $past(up_cur))); // R5

endmodule

// File: rtl/bimode_predictor.sv
module bimode_predictor #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_pc_idx,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_pc_idx,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);

  localparam logic [7:0] WEAK_TAKEN = bimode_pkg::weak_value(1'b1, CTR_W);
  localparam logic [7:0] WEAK_NOT   = bimode_pkg::weak_value(1'b0, CTR_W);

  logic [HIST_W-1:0] ghr_q;
  logic [IDX_W-1:0]  lk_didx, up_didx;
  logic              lk_sel, up_sel;
  logic [1:0]        lk_dir_pred, up_dir_pred, dir_we;

  // Named internal events used by the update rules and the assertions.
  logic up_sel_pred, choice_missed, dir_hit, choice_hold, ch_we;

  bimode_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lk_hash (
    .pc_idx(lk_pc_idx), .hist(ghr_q), .dir_idx(lk_didx));

  bimode_index_hash #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_up_hash (
    .pc_idx(upd_pc_idx), .hist(upd_hist), .dir_idx(up_didx));

  bimode_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W), .INIT(WEAK_NOT)) u_choice (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(lk_pc_idx), .lk_pred(lk_sel),
    .up_idx(upd_pc_idx), .up_pred(up_sel),
    .up_we(ch_we), .up_dir(upd_taken));

  // Slot 0: not-taken-leaning table, slot 1: taken-leaning table.
  for (genvar g = 0; g < 2; g++) begin : g_dir
    bimode_ctr_table #(.IDX_W(IDX_W), .CTR_W(CTR_W),
                       .INIT((g == 1) ? WEAK_TAKEN : WEAK_NOT)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .lk_idx(lk_didx), .lk_pred(lk_dir_pred[g]),
      .up_idx(up_didx), .up_pred(up_dir_pred[g]),
      .up_we(dir_we[g]), .up_dir(upd_taken));
    assign dir_we[g] = upd_valid && (up_sel == 1'(g));
  end

  assign lk_taken      = lk_dir_pred[lk_sel];
  assign lk_hist       = ghr_q;
  assign up_sel_pred   = up_dir_pred[up_sel];
  assign choice_missed = (up_sel != upd_taken);
  assign dir_hit       = (up_sel_pred == upd_taken);
  assign choice_hold   = choice_missed && dir_hit;
  assign ch_we         = upd_valid && !choice_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ghr_q <= '0;
    else if (upd_valid) ghr_q <= {ghr_q[HIST_W-2:0], upd_taken};
  end

  AST_ONE_TABLE_TRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ($countones(dir_we) == 1)); // R5

  AST_IDLE_NO_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> (dir_we == 2'b00) && !ch_we); // R5

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(upd_taken)})); // R7

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(lk_hist)); // R7

endmodule

// File: tb/sim_bimode_predictor.sv
module sim_bimode_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 10;
  localparam int HIST_W = 10;
  localparam int CTR_W  = 2;
  localparam int N      = 1 << IDX_W;
  localparam int HMASK  = (1 << HIST_W) - 1;
  localparam int CMAX   = (1 << CTR_W) - 1;
  localparam int HALF   = 1 << (CTR_W - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IDX_W-1:0]  lk_pc_idx = '0;
  logic              lk_taken;
  logic [HIST_W-1:0] lk_hist;
  logic              upd_valid = 1'b0;
  logic [IDX_W-1:0]  upd_pc_idx = '0;
  logic              upd_taken = 1'b0;
  logic [HIST_W-1:0] upd_hist = '0;

  int errs = 0;
  int checks = 0;
  int m_tk[N];
  int m_nt[N];
  int m_ch[N];
  int m_ghr;

  bimode_predictor #(.IDX_W(IDX_W), .HIST_W(HIST_W), .CTR_W(CTR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_pc_idx(lk_pc_idx), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .upd_valid(upd_valid), .upd_pc_idx(upd_pc_idx),
    .upd_taken(upd_taken), .upd_hist(upd_hist));

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference behaviour written from the requirements.
  function automatic int m_pred(int pc);
    int d = (pc ^ m_ghr) % N;
    if (m_ch[pc] >= HALF) return (m_tk[d] >= HALF) ? 1 : 0;
    return (m_nt[d] >= HALF) ? 1 : 0;
  endfunction

  task automatic m_update(int pc, int t, int h);
    int c = m_ch[pc];
    int d = (pc ^ h) % N;
    bit use_tk = (c >= HALF);
    int cnt = use_tk ? m_tk[d] : m_nt[d];
    bit dir_ok = ((cnt >= HALF) == (t != 0));
    bit ch_ok = ((c >= HALF) == (t != 0));
    if (t != 0) begin
      if (cnt < CMAX) cnt++;
    end else if (cnt > 0) cnt--;
    if (use_tk) m_tk[d] = cnt; else m_nt[d] = cnt;
    if (ch_ok || !dir_ok) begin
      if (t != 0) begin
        if (c < CMAX) c++;
      end else if (c > 0) c--;
      m_ch[pc] = c;
    end
    m_ghr = ((m_ghr << 1) | (t & 1)) & HMASK;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      m_tk[i] = HALF;
      m_nt[i] = HALF - 1;
      m_ch[i] = HALF - 1;
    end
    m_ghr = 0;
    rst_n = 1'b1;
  endtask

  task automatic do_update(int pc, int t, int h);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_pc_idx = IDX_W'(pc);
    upd_taken = t[0];
    upd_hist = HIST_W'(h);
    @(posedge clk);
    m_update(pc, t, h);
    #1 upd_valid = 1'b0;
  endtask

  task automatic look(int pc, string req, int exp);
    @(negedge clk);
    lk_pc_idx = IDX_W'(pc);
    #1;
    check(req, int'(lk_taken), exp, "hand-derived prediction");
    check(req, int'(lk_taken), m_pred(pc), "model prediction");
  endtask

  task automatic look_model(int pc, string req);
    @(negedge clk);
    lk_pc_idx = IDX_W'(pc);
    #1;
    check(req, int'(lk_taken), m_pred(pc), "model prediction");
  endtask

  // R1, R7: reset state.
  task automatic t_reset();
    do_reset();
    #1;
    check("R7", int'(lk_hist), 0, "history after reset");
    look(0, "R1", 0);
    look(16'h040, "R1", 0);
    look(16'h3FF, "R1", 0);
    look(16'h155, "R1", 0);
  endtask

  // R8, R4, R3: initial leanings seen through a choice flip.
  task automatic t_initial_values();
    do_reset();
    do_update(16'h040, 1, 0);           // choice[0x40] -> 2
    look(16'h040, "R8", 1);             // taken table entry 0x41 still weakly taken
    look(16'h080, "R8", 0);             // not-taken table entry 0x81 weakly not-taken
    do_update(16'h080, 0, 0);
    check("R7", int'(lk_hist), 2, "history after T,N");
    look(16'h040, "R4", 1);             // choice by address alone, entry 0x42
    look(16'h080, "R3", 0);
  endtask

  // R6: choice holds while the chosen table is already right.
  task automatic t_choice_hold();
    do_reset();
    do_update(16'h011, 1, 1);
    do_update(16'h011, 1, 1);           // choice[0x11] = 3
    do_update(16'h011, 0, 2);           // choice -> 2
    do_update(16'h011, 0, 2);           // held
    do_update(16'h011, 0, 2);           // held
    check("R7", int'(lk_hist), 16'h018, "history after T,T,N,N,N");
    look(16'h011, "R6", 1);             // taken table entry 0x09 untouched
  endtask

  // R9, R2: saturation at both ends.
  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 12; i++) do_update(16'h0C0, 1, 16'h3FF);
    look(16'h0C0, "R9", 1);
    look(16'h03F, "R2", 0);
    do_reset();
    for (int i = 0; i < 12; i++) do_update(16'h025, 0, 0);
    look(16'h025, "R9", 0);
  endtask

  function automatic int pick_pc(int k);
    case (k % 8)
      0: return 16'h000;
      1: return 16'h001;
      2: return 16'h005;
      3: return 16'h3FF;
      4: return 16'h200;
      5: return 16'h155;
      6: return 16'h02A;
      default: return 16'h010;
    endcase
  endfunction

  // R2, R3, R4, R5, R6, R7: long mixed stream against the model.
  task automatic t_stress();
    do_reset();
    for (int it = 0; it < 2500; it++) begin
      int pc = pick_pc(int'($urandom));
      int hsel = int'($urandom % 4);
      int h = (hsel == 0) ? m_ghr : (hsel == 1) ? 0 : (hsel == 2) ? HMASK
            : int'($urandom) & HMASK;
      int t = ((($urandom % 4) != 0) ? 1 : 0) ^ (pc & 1);
      do_update(pc, t, h);
      look_model(pick_pc(int'($urandom)), "R5");
      if (it % 100 == 0) check("R7", int'(lk_hist), m_ghr, "history in stream");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_initial_values();
    t_choice_hold();
    t_saturate();
    t_stress();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule